// File: doc/BRIEF.md
# Fall-Through Shift-Register FIFO

This block is a first-in first-out buffer of 64 words of 5 bits. It has no read or write pointers. It is built as a chain of storage stages, and each stage carries its own occupancy bit. A word written at the input stage advances one stage per clock until it reaches the last free stage before the output. When the output stage is emptied, the free slot travels backward one stage per clock toward the input. The writer and the reader each have a strobe and a ready flag. Because of this, the two sides can run at unrelated rates, and either side can drive its strobe without looking at the flag (burst use).

The writer raises `shift_in` while `in_ready` is high. The word on `din` is then captured and `in_ready` drops. The word stays in the input stage until `shift_in` goes low again. The reader raises `shift_out` while `out_ready` is high. This takes the word, and `out_ready` drops. The next word is presented only after `shift_out` returns low.

If a strobe is held high, the block hands over words by itself:
- `shift_out` held high on an empty buffer makes each arriving word appear as a one-cycle `out_ready` pulse.
- `shift_in` held high on a full buffer loads `din` as soon as a free slot reaches the input.

Because of these two behaviours, two instances chain with no glue logic. The first instance's `out_ready` drives the second instance's `shift_in`, the second instance's `in_ready` drives the first instance's `shift_out`, and the first instance's `dout` feeds the second instance's `din`. Both strobes are registered once before use. `rst_n` is an asynchronous, active-low reset that empties the whole chain. `oe_n` is active low; when it is high, it floats `dout`.

Top module: `ripple_fifo`

## Requirements
- R1: While `rst_n` is low, at any time and without waiting for a clock edge, `in_ready` is 1, `out_ready` is 0 and `dout` is 0. After release the buffer is empty.
- R2: A word on `din` is captured when `shift_in` is high and `in_ready` is high. `in_ready` falls on the second rising clock edge after `shift_in` rises.
- R3: A captured word advances at most one stage per clock once `shift_in` is low. On an empty buffer, `out_ready` rises on the 65th edge after `shift_in` is lowered, and that word is on `dout`.
- R4: Words leave in the order they entered. Once 64 words are held, `in_ready` stays 0.
- R5: A `shift_in` strobe while 64 words are held adds nothing. Later reads return exactly the 64 held words, and then `out_ready` stays 0.
- R6: Read handshake. `out_ready` falls on the second edge after `shift_out` rises. When the next stage holds a word, that word appears with `out_ready` high on the third edge after `shift_out` is lowered. When no word follows, `out_ready` stays 0 and `dout` keeps the last word read.
- R7: On a full buffer, the slot freed by a read reaches the input stage. `in_ready` rises on the 65th edge after `shift_out` is lowered.
- R8: With `shift_out` held high on an empty buffer, an arriving word raises `out_ready` for exactly one cycle and is taken. `dout` shows that word.
- R9: With `shift_in` held high on a full buffer, the freed slot arriving at the input loads `din` by itself. `in_ready` is high for exactly one cycle.
- R10: When `oe_n` is 1, all five bits of `dout` are high impedance. When `oe_n` is 0, `dout` shows the output stage.
- R11: Two instances chained flag-to-strobe, as described above, form a 128-word buffer that keeps order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for stage moves and strobe sampling |
| rst_n | input | 1 | Asynchronous master reset, active low |
| shift_in | input | 1 | Write strobe |
| din | input | 5 | Word to write |
| in_ready | output | 1 | High when the input stage is empty |
| shift_out | input | 1 | Read strobe |
| oe_n | input | 1 | Output enable, active low |
| dout | output | 5 | Output stage word, or high impedance |
| out_ready | output | 1 | High when the output stage holds an unread word |

## Verification
Each strobe passes through one register before the chain sees it. The flag response therefore lands on the second edge after the strobe rises, and the bench samples the flag on the falling edges after the first and the second rising edges. The long paths are measured by counting rising edges from the negedge on which the strobe is lowered:
- the fall-through of a word on an empty buffer, expected on edge 65;
- the return of a free slot on a full buffer, expected on edge 65;
- the refill of the output stage after a read, expected on edge 3.

The single-cycle pulses of the held-strobe modes are counted over a window much longer than the chain, so that a pulse that is too wide, or an extra pulse, is caught.

// File: rtl/rf_pkg.sv
package rf_pkg;

    // Handshake locks: fresh holds a just-captured word in the input stage
    // until the write strobe falls; taken keeps the output stage closed
    // until the read strobe falls.
    typedef struct packed {
        logic fresh;
        logic taken;
    } rf_lock_t;

    // A lock is set by its event and held only while its strobe stays high.
    function automatic logic next_lock(input logic cur, input logic set_now,
                                       input logic strobe);
        return set_now | (cur & strobe);
    endfunction

endpackage

// File: rtl/rf_strobe_sync.sv
module rf_strobe_sync #(
    parameter int WIDTH = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift_in,
    input  logic             shift_out,
    input  logic [WIDTH-1:0] din,
    output logic             wr_req,
    output logic             rd_req,
    output logic [WIDTH-1:0] wr_data
);

    typedef struct packed {
        logic             si;
        logic             so;
        logic [WIDTH-1:0] data;
    } sync_t;

    sync_t s_d, s_q;

    // Next value: sample both strobes together with the data they qualify.
    always_comb begin
        s_d      = s_q;
        s_d.si   = shift_in;
        s_d.so   = shift_out;
        s_d.data = din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign wr_req  = s_q.si;
    assign rd_req  = s_q.so;
    assign wr_data = s_q.data;

endmodule

// File: rtl/rf_stage_chain.sv
module rf_stage_chain
    import rf_pkg::*;
#(
    parameter int WIDTH = 5,
    parameter int DEPTH = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_req,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_req,
    output logic [WIDTH-1:0] out_data,
    output logic             in_ready,
    output logic             out_ready
);

    localparam int LAST = DEPTH - 1;

    typedef struct packed {
        logic [DEPTH-1:0]            occ;
        logic [DEPTH-1:0][WIDTH-1:0] word;
        rf_lock_t                    lock;
    } chain_t;

    chain_t c_d, c_q;
    logic   capture;
    logic   consume;
    logic [DEPTH-2:0] move;

    always_comb begin
        capture = wr_req && !c_q.occ[0] && !c_q.lock.fresh;
        consume = rd_req && c_q.occ[LAST] && !c_q.lock.taken;

        // A stage hands its word on only when the next stage was empty at
        // the start of the cycle: one stage per clock, both directions.
        for (int i = 0; i < DEPTH - 1; i++) begin
            move[i] = c_q.occ[i] && !c_q.occ[i+1]
                      && ((i != 0) || !c_q.lock.fresh)
                      && ((i + 1 != LAST) || !c_q.lock.taken);
        end

        c_d = c_q;
        for (int i = 0; i < DEPTH - 1; i++) begin
            if (move[i]) begin
                c_d.occ[i]    = 1'b0;
                c_d.occ[i+1]  = 1'b1;
                c_d.word[i+1] = c_q.word[i];
            end
        end
        if (capture) begin
            c_d.occ[0]  = 1'b1;
            c_d.word[0] = wr_data;
        end
        // A read only clears occupancy; the word stays visible.
        if (consume) begin
            c_d.occ[LAST] = 1'b0;
        end
        c_d.lock.fresh = next_lock(c_q.lock.fresh, capture, wr_req);
        c_d.lock.taken = next_lock(c_q.lock.taken, consume, rd_req);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign in_ready  = !c_q.occ[0];
    assign out_ready = c_q.occ[LAST];
    assign out_data  = c_q.word[LAST];

    // R2: a strobe seen with the input stage free always closes it.
    a_r2_in_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && wr_req) |=> !in_ready);

    // R3: occupancy changes by at most one word per clock.
    a_r3_one_step: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($countones(c_q.occ) <= $past($countones(c_q.occ)) + 1) &&
                  ($countones(c_q.occ) + 1 >= $past($countones(c_q.occ)))));

    // R5: a full chain can only lose a word, never gain one.
    a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (&c_q.occ) |=> ($countones(c_q.occ) >= DEPTH - 1));

    // R6: the visible word changes only as out_ready rises.
    a_r6_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!out_ready) |=> (out_ready || $stable(out_data)));

    // R6: while a read strobe is still high, no new word is presented.
    a_r6_taken_closed: assert property (@(posedge clk) disable iff (!rst_n)
        c_q.lock.taken |-> !out_ready);

endmodule

// File: rtl/ripple_fifo.sv
module ripple_fifo #(
    parameter int WIDTH = 5,
    parameter int DEPTH = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift_in,
    input  logic [WIDTH-1:0] din,
    output logic             in_ready,
    input  logic             shift_out,
    input  logic             oe_n,
    output logic [WIDTH-1:0] dout,
    output logic             out_ready
);

    logic             wr_req;
    logic             rd_req;
    logic [WIDTH-1:0] wr_data;
    logic [WIDTH-1:0] out_data;

    rf_strobe_sync #(.WIDTH(WIDTH)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_in (shift_in),
        .shift_out(shift_out),
        .din      (din),
        .wr_req   (wr_req),
        .rd_req   (rd_req),
        .wr_data  (wr_data)
    );

    rf_stage_chain #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_chain (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_req   (wr_req),
        .wr_data  (wr_data),
        .rd_req   (rd_req),
        .out_data (out_data),
        .in_ready (in_ready),
        .out_ready(out_ready)
    );

    assign dout = oe_n ? {WIDTH{1'bz}} : out_data;

endmodule

// File: tb/tb_ripple_fifo.sv
`timescale 1ns/1ps
module tb_ripple_fifo;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       shift_in, shift_out, oe_n;
    logic [4:0] din;
    wire  [4:0] dout;
    logic       in_ready, out_ready;

    logic       c_si, c_so;
    logic [4:0] c_din;
    wire  [4:0] a_q, c_dout;
    logic       a_out_ready, b_in_ready, c_in_ready, c_out_ready;

    int checks = 0;
    int errors = 0;
    logic [4:0] got;

    always #5 clk = ~clk;

    ripple_fifo dut (
        .clk(clk), .rst_n(rst_n), .shift_in(shift_in), .din(din),
        .in_ready(in_ready), .shift_out(shift_out), .oe_n(oe_n),
        .dout(dout), .out_ready(out_ready));

    ripple_fifo casc_a (
        .clk(clk), .rst_n(rst_n), .shift_in(c_si), .din(c_din),
        .in_ready(c_in_ready), .shift_out(b_in_ready), .oe_n(1'b0),
        .dout(a_q), .out_ready(a_out_ready));

    ripple_fifo casc_b (
        .clk(clk), .rst_n(rst_n), .shift_in(a_out_ready), .din(a_q),
        .in_ready(b_in_ready), .shift_out(c_so), .oe_n(1'b0),
        .dout(c_dout), .out_ready(c_out_ready));

    function automatic logic [4:0] sv(input int i);
        return 5'((i * 11 + 5) % 32);
    endfunction

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic push(input logic [4:0] w);
        int n;
        n = 0;
        while (!in_ready && n < 400) begin tick(); n++; end
        din = w; shift_in = 1'b1;
        tick(); n = 0;
        while (in_ready && n < 20) begin tick(); n++; end
        shift_in = 1'b0;
    endtask

    task automatic pop(output logic [4:0] w);
        int n;
        n = 0;
        while (!out_ready && n < 400) begin tick(); n++; end
        w = dout; shift_out = 1'b1;
        tick(); n = 0;
        while (out_ready && n < 20) begin tick(); n++; end
        shift_out = 1'b0;
    endtask

    task automatic cpush(input logic [4:0] w);
        int n;
        n = 0;
        while (!c_in_ready && n < 400) begin tick(); n++; end
        c_din = w; c_si = 1'b1;
        tick(); n = 0;
        while (c_in_ready && n < 20) begin tick(); n++; end
        c_si = 1'b0;
    endtask

    task automatic cpop(output logic [4:0] w);
        int n;
        n = 0;
        while (!c_out_ready && n < 400) begin tick(); n++; end
        w = c_dout; c_so = 1'b1;
        tick(); n = 0;
        while (c_out_ready && n < 20) begin tick(); n++; end
        c_so = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int ko, ki, pulses;
        logic [4:0] seen;
        rst_n = 1'b0; shift_in = 1'b0; shift_out = 1'b0; oe_n = 1'b0; din = '0;
        c_si = 1'b0; c_so = 1'b0; c_din = '0;
        tick(); tick();
        // R1 reset state
        chk("R1 in_ready", int'(in_ready), 1);
        chk("R1 out_ready", int'(out_ready), 0);
        chk("R1 dout", int'(dout), 0);
        rst_n = 1'b1;
        tick();

        // R2 capture timing, R3 fall-through latency
        din = 5'h15; shift_in = 1'b1;
        tick(); chk("R2 in_ready after edge 1", int'(in_ready), 1);
        tick(); chk("R2 in_ready after edge 2", int'(in_ready), 0);
        shift_in = 1'b0;
        ko = 0;
        for (int k = 1; k <= 200; k++) begin
            tick();
            if (out_ready) begin ko = k; break; end
        end
        chk("R3 fall-through edges", ko, 65);
        chk("R3 word at output", int'(dout), 'h15);
        pop(got);
        chk("R3 popped word", int'(got), 'h15);
        repeat (10) tick();
        chk("R6 out_ready stays low", int'(out_ready), 0);
        chk("R6 last word kept", int'(dout), 'h15);

        // R4 fill to capacity
        for (int i = 0; i < 64; i++) push(sv(i));
        repeat (200) tick();
        chk("R4 in_ready low when full", int'(in_ready), 0);
        chk("R4 out_ready high when full", int'(out_ready), 1);

        // R5 overflow strobe ignored
        din = 5'h1e; shift_in = 1'b1;
        repeat (20) tick();
        chk("R5 in_ready low under overflow", int'(in_ready), 0);
        shift_in = 1'b0;
        repeat (10) tick();

        // R6 read timing and R7 bubble-up latency
        chk("R4 first word", int'(dout), int'(sv(0)));
        shift_out = 1'b1;
        tick(); chk("R6 out_ready after edge 1", int'(out_ready), 1);
        tick(); chk("R6 out_ready after edge 2", int'(out_ready), 0);
        shift_out = 1'b0;
        ko = 0; ki = 0;
        for (int k = 1; k <= 200; k++) begin
            tick();
            if (out_ready && ko == 0) ko = k;
            if (in_ready && ki == 0) begin ki = k; break; end
        end
        chk("R6 refill edges", ko, 3);
        chk("R7 bubble-up edges", ki, 65);
        chk("R4 second word", int'(dout), int'(sv(1)));

        // R9 held shift_in on full
        push(5'h0a);
        repeat (10) tick();
        din = 5'h13; shift_in = 1'b1;
        repeat (10) tick();
        chk("R9 no load while full", int'(in_ready), 0);
        pop(got);
        chk("R4 order word 1", int'(got), int'(sv(1)));
        pulses = 0;
        for (int k = 0; k < 200; k++) begin
            tick();
            if (in_ready) pulses++;
        end
        chk("R9 in_ready pulse cycles", pulses, 1);
        shift_in = 1'b0;
        repeat (5) tick();
        for (int i = 2; i < 64; i++) begin
            pop(got);
            chk("R4 order", int'(got), int'(sv(i)));
        end
        pop(got); chk("R5 word before overflow-era loads", int'(got), 'h0a);
        pop(got); chk("R9 auto-loaded word", int'(got), 'h13);
        repeat (100) tick();
        chk("R5 no extra word", int'(out_ready), 0);
        chk("R6 last word kept after drain", int'(dout), 'h13);

        // R8 held shift_out on empty
        shift_out = 1'b1;
        repeat (3) tick();
        push(5'h07);
        pulses = 0; seen = '0;
        for (int k = 0; k < 200; k++) begin
            tick();
            if (out_ready) begin pulses++; seen = dout; end
        end
        chk("R8 out_ready pulse cycles", pulses, 1);
        chk("R8 pulsed word", int'(seen), 'h07);
        shift_out = 1'b0;
        repeat (5) tick();
        chk("R8 word taken", int'(out_ready), 0);

        // R10 output enable
        oe_n = 1'b1; tick();
        checks++;
        if (dout !== 5'bzzzzz) begin
            errors++;
            $display("FAIL R10 dout float: actual %b expected zzzzz", dout);
        end
        oe_n = 1'b0; tick();
        chk("R10 dout driven", int'(dout), 'h07);

        // R1 asynchronous reset mid-run
        push(5'h11); push(5'h12); push(5'h14);
        repeat (100) tick();
        chk("R1 precondition out_ready", int'(out_ready), 1);
        #2 rst_n = 1'b0;
        #1;
        chk("R1 async in_ready", int'(in_ready), 1);
        chk("R1 async out_ready", int'(out_ready), 0);
        chk("R1 async dout", int'(dout), 0);
        tick(); rst_n = 1'b1;
        repeat (100) tick();
        chk("R1 emptied", int'(out_ready), 0);

        // R11 cascade of two
        for (int i = 0; i < 128; i++) cpush(5'((i * 13 + 1) % 32));
        repeat (300) tick();
        chk("R11 chain full", int'(c_in_ready), 0);
        for (int i = 0; i < 128; i++) begin
            cpop(got);
            chk("R11 chain order", int'(got), (i * 13 + 1) % 32);
        end
        repeat (200) tick();
        chk("R11 chain empty", int'(c_out_ready), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule